// File: doc/BRIEF.md
# Sequenced Max-Star Add-Compare-Select Unit

This block is one add-compare-select datapath for a log-domain soft-output trellis decoder. On every clock it can do one elementary operation. It adds a branch metric to a path metric to form a candidate. It compares that candidate with a competing metric held in one of its own scratch registers and keeps the larger one. It then adds a small correction, read from a lookup table of ln(1+e^-|d|), where |d| is the size of the difference. Metrics are signed fixed point with two fractional bits, so one LSB is a quarter nat.

Three private scratch registers (R1, R2, R3) carry partial results from one cycle to the next. The max-star combination of four terms therefore runs as a fixed four-operation sequence on a single unit:

1. load R1;
2. merge into R2;
3. merge into R3;
4. emit the result.

A 2-bit operation code, qualified by a valid input, picks the operand source and the destination. A surrounding controller issues the sequences and can run them back to back. Memory banks and window control lie outside this block.

Top module: `acs_seq_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `metric_out`, `done` and the scratch registers R1, R2 and R3 are all cleared to zero.
- R2: The candidate is `pm_in + bm_in`, taken as 10-bit two's complement and saturated to the range [-512, 511].
- R3: Operation code 0 (load) writes the candidate into R1 and leaves R2, R3 and `metric_out` unchanged.
- R4: Operation code 1 writes maxstar(R1, candidate) into R2. Operation code 2 writes maxstar(R2, candidate) into R3.
- R5: Operation code 3 (emit) makes `metric_out` equal maxstar(R3, candidate) one clock after it is accepted. `done` is high for exactly the clock after each accepted emit and low otherwise. `metric_out` holds its value between emits.
- R6: maxstar(a, b) = max(a, b) + T[k], where k = min(|a - b| >> 1, 7) and T = {3, 2, 1, 1, 1, 0, 0, 0} for k = 0..7. The sum is saturated to the 10-bit range.
- R7: Exactly one operation is accepted per clock, and only while `op_valid` is high. A clock with `op_valid` low changes none of R1, R2, R3 or `metric_out`.
- R8: A new sequence may start on the clock right after an emit. Its load overwrites R1 whatever R1 held before, so consecutive sequences are independent.
- R9: A correction that would push a result past 511 leaves the result at 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is presented this clock |
| op_code | input | 2 | 0 load R1, 1 merge into R2, 2 merge into R3, 3 emit |
| pm_in | input | 10 | Path metric, signed |
| bm_in | input | 10 | Branch metric, signed |
| metric_out | output | 10 | Last emitted max-star result, signed |
| done | output | 1 | One-clock strobe following an accepted emit |

## Verification
The assertions check these properties on every cycle:

- the timing of the `done` strobe relative to accepted emits;
- that idle clocks and loads leave the scratch and output registers untouched;
- that a merge or emit never produces a value below the scratch operand it combined.

What the assertions cannot show is the exact numeric value of the correction, the saturation of the candidate, or how results pass through the R1, R2, R3 chain. The bench shows these by comparing every emitted result with an independent model. It drives random four-term sequences with idle gaps, random operation orders, and directed cases at the saturation limits and at zero difference.

// File: rtl/acs_seq_pkg.sv
// Package acs_seq_pkg
// Shared operation codes and the correction table for the sequenced ACS unit.
// Assumes metrics carry two fractional bits; the table is in those units.
package acs_seq_pkg;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_MERGE1 = 2'd1,
        OP_MERGE2 = 2'd2,
        OP_EMIT   = 2'd3
    } acs_op_e;

    localparam int LUT_IDX_W = 3;
    localparam int LUT_LAST  = (1 << LUT_IDX_W) - 1;
    localparam int CORR_W    = 2;

    // ln(1+e^-x) in quarter-nat units, x sampled in half-nat steps
    function automatic logic [CORR_W-1:0] corr_lut(input logic [LUT_IDX_W-1:0] idx);
        case (idx)
            3'd0:    corr_lut = 2'd3;
            3'd1:    corr_lut = 2'd2;
            3'd2,
            3'd3,
            3'd4:    corr_lut = 2'd1;
            default: corr_lut = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/acs_sat_add.sv
// Module acs_sat_add
// Signed saturating adder: returns a+b clamped to the W-bit two's complement range.
// Assumes both operands are W-bit two's complement; purely combinational.
module acs_sat_add #(
    parameter int W = 10
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] sum
);
    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W:0] wide;

    // sign-extended add, one guard bit
    assign wide = {a[W-1], a} + {b[W-1], b};

    // clamp when the guard bit disagrees with the result sign
    always_comb begin
        if (wide[W] != wide[W-1])
            sum = wide[W] ? MINV : MAXV;
        else
            sum = wide[W-1:0];
    end
endmodule

// File: rtl/acs_maxstar.sv
// Module acs_maxstar
// Compare-select with table correction: y = sat(max(a,b) + T[min(|a-b|>>SHIFT, 7)]).
// Assumes W-bit signed operands; the difference is formed in W+1 bits so it cannot wrap.
module acs_maxstar
    import acs_seq_pkg::*;
#(
    parameter int W     = 10,
    parameter int SHIFT = 1
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    logic [W:0]              diff;
    logic [W:0]              mag;
    logic [W:0]              scaled;
    logic                    a_wins;
    logic signed [W-1:0]     survivor;
    logic [LUT_IDX_W-1:0]    idx;
    logic signed [W-1:0]     corr_ext;

    // difference and magnitude of the two competitors
    assign diff   = {a[W-1], a} - {b[W-1], b};
    assign a_wins = ~diff[W];
    assign mag    = a_wins ? diff : (~diff + 1'b1);

    // select the survivor
    assign survivor = a_wins ? a : b;

    // quantize and saturate the table index
    assign scaled = mag >> SHIFT;
    assign idx    = (scaled > (W+1)'(LUT_LAST)) ? LUT_IDX_W'(LUT_LAST) : scaled[LUT_IDX_W-1:0];

    // zero-extended correction term
    assign corr_ext = $signed({{(W-CORR_W){1'b0}}, corr_lut(idx)});

    acs_sat_add #(.W(W)) u_corr_add (
        .a   (survivor),
        .b   (corr_ext),
        .sum (y)
    );
endmodule

// File: rtl/acs_seq_unit.sv
// Module acs_seq_unit
// One add-compare-select datapath that builds a four-term max-star over four
// consecutive operations, keeping partial results in private registers R1..R3.
// Assumes a controller issues load, merge1, merge2, emit in order; any order is
// legal and acts per the opcode. Synchronous active-low reset.
module acs_seq_unit
    import acs_seq_pkg::*;
#(
    parameter int W     = 10,
    parameter int SHIFT = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [1:0]          op_code,
    input  logic signed [W-1:0] pm_in,
    input  logic signed [W-1:0] bm_in,
    output logic signed [W-1:0] metric_out,
    output logic                done
);
    logic signed [W-1:0] cand;
    logic signed [W-1:0] base;
    logic signed [W-1:0] merged;
    logic signed [W-1:0] r1_q, r2_q, r3_q;
    logic                emit_now;

    // candidate = saturated path + branch metric
    acs_sat_add #(.W(W)) u_cand_add (
        .a   (pm_in),
        .b   (bm_in),
        .sum (cand)
    );

    // pick the scratch register that competes with the candidate
    always_comb begin
        case (op_code)
            OP_MERGE2: base = r2_q;
            OP_EMIT:   base = r3_q;
            default:   base = r1_q;
        endcase
    end

    acs_maxstar #(.W(W), .SHIFT(SHIFT)) u_maxstar (
        .a (base),
        .b (cand),
        .y (merged)
    );

    assign emit_now = op_valid && (op_code == OP_EMIT);

    // scratch register writes, one destination per accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1_q <= '0;
            r2_q <= '0;
            r3_q <= '0;
        end else if (op_valid) begin
            case (op_code)
                OP_LOAD:   r1_q <= cand;
                OP_MERGE1: r2_q <= merged;
                OP_MERGE2: r3_q <= merged;
                default:   ;
            endcase
        end
    end

    // result register and completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            metric_out <= '0;
            done       <= 1'b0;
        end else begin
            done <= emit_now;
            if (emit_now)
                metric_out <= merged;
        end
    end

    AST_EMIT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        emit_now |=> done); // R5
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !emit_now |=> !done); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(r1_q) && $stable(r2_q) && $stable(r3_q) && $stable(metric_out))); // R7
    AST_LOAD_ONLY_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LOAD) |=> ($stable(r2_q) && $stable(r3_q) && $stable(metric_out))); // R3
    AST_MERGE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_MERGE1) |=> (r2_q >= $past(r1_q))); // R6
    AST_EMIT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        emit_now |=> (metric_out >= $past(r3_q))); // R6
endmodule

// File: tb/acs_seq_unit_test.sv
`timescale 1ns/1ps
module acs_seq_unit_test;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [1:0]        op_code = 2'd0;
    logic signed [9:0] pm_in = '0;
    logic signed [9:0] bm_in = '0;
    logic signed [9:0] metric_out;
    logic              done;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    int m_r1 = 0, m_r2 = 0, m_r3 = 0, m_out = 0;

    acs_seq_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .pm_in(pm_in), .bm_in(bm_in), .metric_out(metric_out), .done(done)
    );

    always #2.5 clk = ~clk;

    function automatic int clamp(input int v);
        if (v > 511) return 511;
        if (v < -512) return -512;
        return v;
    endfunction

    function automatic int ref_maxstar(input int a, input int b);
        int mx, k, t;
        mx = (a >= b) ? a : b;
        k  = ((a >= b) ? (a - b) : (b - a)) / 2;
        if (k > 7) k = 7;
        case (k)
            0: t = 3;
            1: t = 2;
            2, 3, 4: t = 1;
            default: t = 0;
        endcase
        return clamp(mx + t);
    endfunction

    function automatic int rnd_metric();
        return int'($signed(10'($urandom))) ;
    endfunction

    task automatic check(input string tag, input int got_m, input int exp_m,
                         input bit got_d, input bit exp_d);
        total++;
        if (got_m != exp_m || got_d != exp_d) begin
            bad++;
            $display("FAIL %s: metric=%0d done=%0d expected metric=%0d done=%0d",
                     tag, got_m, got_d, exp_m, exp_d);
        end
    endtask

    // drive one clock of stimulus at a falling edge, check at the next falling edge
    task automatic step(input bit vld, input int op, input int pm, input int bm, input string tag);
        int cand;
        bit exp_done;
        op_valid = vld;
        op_code  = op[1:0];
        pm_in    = pm[9:0];
        bm_in    = bm[9:0];
        cand = clamp(pm + bm);
        exp_done = vld && (op == 3);
        if (vld) begin
            case (op)
                0: m_r1 = cand;
                1: m_r2 = ref_maxstar(m_r1, cand);
                2: m_r3 = ref_maxstar(m_r2, cand);
                default: m_out = ref_maxstar(m_r3, cand);
            endcase
        end
        @(negedge clk);
        check(tag, int'(metric_out), m_out, done, exp_done);
    endtask

    task automatic sequence4(input int p0, input int b0, input int p1, input int b1,
                             input int p2, input int b2, input int p3, input int b3,
                             input string tag);
        step(1'b1, 0, p0, b0, tag);
        step(1'b1, 1, p1, b1, tag);
        step(1'b1, 2, p2, b2, tag);
        step(1'b1, 3, p3, b3, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset with a valid emit presented must not load anything
        op_valid = 1'b1; op_code = 2'd3; pm_in = 10'sd100; bm_in = 10'sd50;
        repeat (3) @(negedge clk);
        check("R1 reset state", int'(metric_out), 0, done, 1'b0);
        op_valid = 1'b0;
        rst_n = 1'b1;
        // R1: emit straight after reset shows R3 is zero: maxstar(0, 8)
        step(1'b1, 3, 5, 3, "R1 cleared R3");
        // R2/R9: saturated candidates
        sequence4(511, 511, -512, -512, 511, 300, -512, -1, "R2 R9 saturation");
        sequence4(-512, -512, -512, -512, -512, -512, -512, -512, "R2 negative floor");
        // R6: all-zero terms exercise small-difference table entries
        sequence4(0, 0, 0, 0, 0, 0, 0, 0, "R6 equal terms");
        sequence4(0, 0, 10, 0, -20, 0, 3, 0, "R6 spread terms");
        // R8: back to back, second sequence must not see the first's R1
        sequence4(400, 0, -400, 0, -400, 0, -400, 0, "R8 first");
        sequence4(-300, 0, -300, 1, -301, 0, -299, 0, "R8 second");
        // R7: idle clocks between operations change nothing
        step(1'b1, 0, 40, 2, "R7 load");
        step(1'b0, 1, 500, 500, "R7 idle");
        step(1'b0, 3, 500, 500, "R7 idle emit code");
        step(1'b1, 1, 41, 0, "R7 merge1");
        step(1'b0, 0, -500, 0, "R7 idle load code");
        step(1'b1, 2, 39, 4, "R7 merge2");
        step(1'b1, 3, 45, -1, "R7 emit");
        // R3 R4 R5: random full sequences with idle gaps
        for (int s = 0; s < 300; s++) begin
            for (int o = 0; o < 4; o++) begin
                if (($urandom % 4) == 0)
                    step(1'b0, int'($urandom % 4), rnd_metric(), rnd_metric(), "R7 random idle");
                step(1'b1, o, rnd_metric(), rnd_metric(), "R4 R5 random sequence");
            end
        end
        // R3 R4: random operation order
        for (int i = 0; i < 400; i++)
            step(($urandom % 5) != 0, int'($urandom % 4), rnd_metric() / 4, rnd_metric() / 4,
                 "R3 R4 random order");
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule